// File: doc/BRIEF.md
# Spread-Spectrum Clock Modulator Sequencer

This block sits behind a PLL and governs a digital model of a spread-spectrum clock modulator. Software powers the modulator up through a control register and waits out a fixed start-up interval counted in control-clock cycles. It then loads a parameter register and sets a modulation enable. Modulation begins only when the PLL reports lock. From then on a running flag tells software that the modulated clock may be chosen as a base-clock source.

While running, the block emits a one-cycle `mod_tick` pulse at the end of every modulated period. Period lengths swing around a nominal length along a triangular profile. The average period therefore equals the nominal one, and the accumulated phase offset against an unmodulated clock stays bounded and returns to zero once per profile. Shutdown runs in the reverse order. Software clears the enable, and the block finishes the current profile before it drops the running flag. Only then may the power bit be cleared.

Top module: `cmod_seq_top`

## Requirements
- R1: After reset the control register reads 0x10: bit 0 power = 0, bit 1 enable = 0, bit 3 running = 0, bit 4 always reads 1, and every other bit reads 0. The parameter register reads 0x00, and `mod_run` and `mod_tick` are 0.
- R2: A write that takes the power bit (bit 0) from 0 to 1 starts a start-up wait of STARTUP_CYC cycles. With enable, lock and a loaded parameter already present, `mod_run` rises after exactly STARTUP_CYC+1 clock edges, counted from the write edge.
- R3: `mod_run` rises on the edge after enable, start-up complete, `pll_locked` and "parameter loaded" are all true together. "Parameter loaded" means at least one parameter write has been accepted since reset. If any one of these is missing, `mod_run` stays 0.
- R4: Parameter fields are degree in bits [3:0] and nominal period in bits [7:4]. The effective nominal period is the larger of the field and 2. The effective degree D is the smaller of the degree field and the nominal period minus 1. The profile length L is 4·D steps, or 1 step when D = 0.
- R5: While running, the period of profile step s, in clock cycles, is the nominal period plus t(s). Here t(s) = s for s ≤ D, t(s) = 2D−s for D < s ≤ 3D, and t(s) = s−4D above that. Steps advance 0..L−1 and wrap.
- R6: Summed over consecutive ticks, the difference between the measured periods and the nominal period never exceeds D² in magnitude. It is exactly 0 after every whole profile.
- R7: After the enable is cleared, `mod_run` falls on the edge of the tick that ends step L−1, so the accumulated phase offset is 0 at stop. Control bit 3 reads the running state.
- R8: A control write with bit 0 = 0 while `mod_run` is 1 leaves the power bit at 1. The enable field of the same write still takes effect.
- R9: A parameter write while `mod_run` is 1 is ignored, and the parameter register keeps its value.
- R10: Clearing the power bit while not running removes start-up completion. A later power-up waits the full STARTUP_CYC again.
- R11: `mod_tick` is never 1 while `mod_run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the modulated periods are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 0 power, bit 1 enable |
| ctrl_rdata | output | 8 | Control readback: bit 0 power, bit 1 enable, bit 3 running, bit 4 fixed 1 |
| parm_we | input | 1 | Parameter register write strobe |
| parm_wdata | input | 8 | Parameter write data: [7:4] nominal period, [3:0] degree |
| parm_rdata | output | 8 | Parameter register readback |
| pll_locked | input | 1 | PLL lock indication |
| mod_run | output | 1 | Modulated clock valid |
| mod_tick | output | 1 | One-cycle pulse at the end of each modulated period |

## Verification
Two functions can meet in one cycle: the power-clear guard and the stop at the profile boundary. A control write of zero that lands on the edge where the running flag falls must still be refused, because the flag was 1 when that edge sampled it. The bench holds a zero control write active every cycle through the whole stop. It then checks that the power bit still reads 1 in the cycle after `mod_run` falls and reads 0 one cycle later. The same stop is judged by the tick monitor, which requires the accumulated phase offset to be exactly zero when the flag drops.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  // width of each parameter-register field (degree, nominal period)
  localparam int unsigned FLD_W  = 4;
  localparam int unsigned PARM_W = 2 * FLD_W;
  // step index and period widths: 4*(2^FLD_W-1) and 2*(2^FLD_W) both fit
  localparam int unsigned STEP_W = FLD_W + 2;
  localparam int unsigned PER_W  = FLD_W + 2;
  // control register bit positions
  localparam int unsigned CB_PWR = 0;
  localparam int unsigned CB_EN  = 1;
  localparam int unsigned CB_RUN = 3;
  localparam int unsigned CB_ONE = 4;

  function automatic int unsigned eff_nom(input int unsigned field);
    return (field < 2) ? 2 : field;
  endfunction

  function automatic int unsigned eff_deg(input int unsigned dfield, input int unsigned nom);
    return (dfield > nom - 1) ? nom - 1 : dfield;
  endfunction

  function automatic int unsigned prof_len(input int unsigned deg);
    return (deg == 0) ? 1 : 4 * deg;
  endfunction

  // triangular period offset for step s of a profile of degree d
  function automatic int tri_delta(input int s, input int d);
    if (s <= d) return s;
    if (s <= 3 * d) return 2 * d - s;
    return s - 4 * d;
  endfunction

  function automatic int unsigned step_period(input int unsigned nom, input int unsigned deg,
                                              input int unsigned s);
    return int'(nom) + tri_delta(int'(s), int'(deg));
  endfunction

endpackage

// File: rtl/cmod_ctrl_regs.sv
module cmod_ctrl_regs
  import cmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_bits,
  input  logic              parm_we,
  input  logic [PARM_W-1:0] parm_wdata,
  input  logic              run,
  output logic              pwr,
  output logic              en,
  output logic              pwr_rise,
  output logic [PARM_W-1:0] parm,
  output logic              loaded
);
  logic pwr_clr_blocked;
  logic parm_take;

  // a request to power down while running is refused
  assign pwr_clr_blocked = ctrl_we & ~ctrl_bits[CB_PWR] & run;
  assign pwr_rise        = ctrl_we & ctrl_bits[CB_PWR] & ~pwr;
  assign parm_take       = parm_we & ~run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr    <= 1'b0;
      en     <= 1'b0;
      parm   <= '0;
      loaded <= 1'b0;
    end else begin
      if (ctrl_we) begin
        pwr <= ctrl_bits[CB_PWR] | pwr_clr_blocked;
        en  <= ctrl_bits[CB_EN];
      end
      if (parm_take) begin
        parm   <= parm_wdata;
        loaded <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmod_startup_timer.sv
module cmod_startup_timer #(
  parameter int unsigned STARTUP_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic pwr_rise,
  output logic ready
);
  localparam int unsigned CNT_W = (STARTUP_CYC < 1) ? 1 : $clog2(STARTUP_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign ready    = pwr & cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (pwr_rise) begin
      cnt_q <= CNT_W'(STARTUP_CYC);
    end else if (!pwr) begin
      cnt_q <= '0;
    end else if (!cnt_zero) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmod_profile_gen.sv
module cmod_profile_gen
  import cmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok,
  input  logic              en,
  input  logic [PARM_W-1:0] parm,
  output logic              run,
  output logic              tick,
  output logic              last_step
);
  logic [PER_W-1:0]  nom_v;
  logic [STEP_W-1:0] deg_v;
  logic [STEP_W-1:0] len_v;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nxt;
  logic [PER_W-1:0]  pc_q;
  logic [PER_W-1:0]  per_first;
  logic [PER_W-1:0]  per_nxt;
  logic              start;
  logic              stop_now;

  always_comb begin
    nom_v     = PER_W'(eff_nom(int'(parm[PARM_W-1:FLD_W])));
    deg_v     = STEP_W'(eff_deg(int'(parm[FLD_W-1:0]), int'(nom_v)));
    len_v     = STEP_W'(prof_len(int'(deg_v)));
    last_step = (step_q == len_v - STEP_W'(1));
    step_nxt  = last_step ? '0 : step_q + STEP_W'(1);
    per_first = PER_W'(step_period(int'(nom_v), int'(deg_v), 0) - 1);
    per_nxt   = PER_W'(step_period(int'(nom_v), int'(deg_v), int'(step_nxt)) - 1);
  end

  assign tick     = run & (pc_q == '0);
  assign start    = ~run & en & go_ok;
  assign stop_now = tick & last_step & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      step_q <= '0;
      pc_q   <= '0;
    end else if (start) begin
      run    <= 1'b1;
      step_q <= '0;
      pc_q   <= per_first;
    end else if (stop_now) begin
      run    <= 1'b0;
      step_q <= '0;
      pc_q   <= '0;
    end else if (tick) begin
      step_q <= step_nxt;
      pc_q   <= per_nxt;
    end else if (run) begin
      pc_q   <= pc_q - PER_W'(1);
    end
  end
endmodule

// File: rtl/cmod_seq_top.sv
module cmod_seq_top
  import cmod_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic              parm_we,
  input  logic [PARM_W-1:0] parm_wdata,
  output logic [PARM_W-1:0] parm_rdata,
  input  logic              pll_locked,
  output logic              mod_run,
  output logic              mod_tick
);
  logic              pwr;
  logic              mod_en;
  logic              pwr_rise;
  logic              loaded;
  logic              ready;
  logic              go_ok;
  logic              last_step;
  logic [PARM_W-1:0] parm;

  cmod_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_bits  (ctrl_wdata[1:0]),
    .parm_we    (parm_we),
    .parm_wdata (parm_wdata),
    .run        (mod_run),
    .pwr        (pwr),
    .en         (mod_en),
    .pwr_rise   (pwr_rise),
    .parm       (parm),
    .loaded     (loaded)
  );

  cmod_startup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr      (pwr),
    .pwr_rise (pwr_rise),
    .ready    (ready)
  );

  assign go_ok = ready & pll_locked & loaded;

  cmod_profile_gen u_prof (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_ok     (go_ok),
    .en        (mod_en),
    .parm      (parm),
    .run       (mod_run),
    .tick      (mod_tick),
    .last_step (last_step)
  );

  always_comb begin
    ctrl_rdata         = '0;
    ctrl_rdata[CB_PWR] = pwr;
    ctrl_rdata[CB_EN]  = mod_en;
    ctrl_rdata[CB_RUN] = mod_run;
    ctrl_rdata[CB_ONE] = 1'b1;
  end

  assign parm_rdata = parm;
endmodule

// File: rtl/cmod_seq_chk.sv
module cmod_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr,
  input logic       mod_en,
  input logic       go_ok,
  input logic       ready,
  input logic       last_step,
  input logic       mod_run,
  input logic       mod_tick,
  input logic [7:0] parm_rdata
);
  // R3: running starts only from the full set of start conditions
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_run) |-> $past(go_ok && mod_en));

  // R8: power bit never drops while running
  a_r8_no_pwr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr) |-> !$past(mod_run));

  // R7: run ends only on the final tick of a profile with enable cleared
  a_r7_stop_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_run) |-> $past(mod_tick && last_step && !mod_en));

  // R11: no ticks outside running
  a_r11_tick_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick |-> mod_run);

  // R2: running implies power and completed start-up
  a_r2_run_powered: assert property (@(posedge clk) disable iff (!rst_n)
    mod_run |-> (pwr && ready));

  // R9: parameter frozen while running
  a_r9_parm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_run && $past(mod_run)) |-> $stable(parm_rdata));
endmodule

bind cmod_seq_top cmod_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr        (pwr),
  .mod_en     (mod_en),
  .go_ok      (go_ok),
  .ready      (ready),
  .last_step  (last_step),
  .mod_run    (mod_run),
  .mod_tick   (mod_tick),
  .parm_rdata (parm_rdata)
);

// File: tb/cmod_seq_top_tb_top.sv
module cmod_seq_top_tb_top;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       parm_we = 1'b0;
  logic [7:0] parm_wdata = '0;
  logic [7:0] parm_rdata;
  logic       pll_locked = 1'b0;
  logic       mod_run;
  logic       mod_tick;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // monitor state
  int b_nom = 2, b_deg = 0, b_len = 1;
  int cyc = 0, last_t = 0, j = 0, cum = 0;
  bit seen = 0, prev_run = 0;

  always #10 clk = ~clk;

  cmod_seq_top #(.STARTUP_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .parm_we(parm_we), .parm_wdata(parm_wdata),
    .parm_rdata(parm_rdata), .pll_locked(pll_locked), .mod_run(mod_run),
    .mod_tick(mod_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bn(input int f); return (f < 2) ? 2 : f; endfunction
  function automatic int bd(input int d, input int n); return (d < n) ? d : n - 1; endfunction
  function automatic int bl(input int d); return (d == 0) ? 1 : d * 4; endfunction
  function automatic int btri(input int s, input int d);
    int v;
    if (d == 0) return 0;
    v = ((s + 3 * d) % (4 * d)) - 2 * d;
    if (v < 0) v = -v;
    return v - d;
  endfunction

  // tick monitor: periods (R5), phase bound and return (R6), stop point (R7), R11
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mod_tick && !mod_run) chk(0, "R11 tick while idle", 1, 0);
      if (mod_tick) begin
        if (seen) begin
          chk((cyc - last_t) == b_nom + btri((j + 1) % b_len, b_deg),
              "R5 period", cyc - last_t, b_nom + btri((j + 1) % b_len, b_deg));
          cum += (cyc - last_t) - b_nom;
          j++;
          chk(cum <= b_deg * b_deg && -cum <= b_deg * b_deg, "R6 phase bound", cum, b_deg * b_deg);
          if (j % b_len == 0) chk(cum == 0, "R6 phase return", cum, 0);
        end
        seen = 1;
        last_t = cyc;
      end
      if (prev_run && !mod_run) begin
        chk(cum == 0, "R7 stop phase", cum, 0);
        seen = 0; cum = 0; j = 0;
      end
      prev_run = mod_run;
    end
  end

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(posedge clk); #1 ctrl_we = 1'b0;
  endtask

  task automatic wr_parm(input logic [7:0] d);
    @(negedge clk); parm_we = 1'b1; parm_wdata = d;
    @(posedge clk); #1 parm_we = 1'b0;
  endtask

  task automatic set_model(input logic [7:0] p);
    b_nom = bn(int'(p[7:4]));
    b_deg = bd(int'(p[3:0]), b_nom);
    b_len = bl(b_deg);
  endtask

  task automatic wait_fall(input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (mod_run && n < 3000);
    chk(!mod_run, tag, mod_run, 0);
  endtask

  // power-up from off with enable: run exactly after S+1 edges
  task automatic power_timed(input string tag);
    wr_ctrl(8'h03);
    repeat (S) @(posedge clk);
    @(negedge clk); chk(mod_run == 1'b0, tag, mod_run, 0);
    @(negedge clk); chk(mod_run == 1'b1, tag, mod_run, 1);
  endtask

  task automatic run_round(input logic [7:0] p, input int cycles);
    wr_parm(p);
    set_model(p);
    @(negedge clk); chk(parm_rdata == p, "R4 parameter load", parm_rdata, p);
    wr_ctrl(8'h03);
    repeat (cycles) @(posedge clk);
    wr_ctrl(8'h01);
    wait_fall("R7 run clears");
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata == 8'h10, "R1 ctrl reset", ctrl_rdata, 8'h10);
    chk(parm_rdata == 8'h00, "R1 parm reset", parm_rdata, 0);
    chk(!mod_run && !mod_tick, "R1 outputs idle", {mod_run, mod_tick}, 0);

    // no parameter loaded yet: must not run
    pll_locked = 1'b1;
    wr_ctrl(8'h03);
    repeat (S + 5) @(negedge clk);
    chk(!mod_run, "R3 needs parameter", mod_run, 0);
    set_model(8'h83);
    wr_parm(8'h83);
    @(negedge clk); chk(!mod_run, "R3 start edge", mod_run, 0);
    @(negedge clk); chk(mod_run, "R3 start after load", mod_run, 1);
    chk(ctrl_rdata == 8'h1B, "R7 running bit", ctrl_rdata, 8'h1B);
    repeat (300) @(posedge clk);

    // parameter write while running ignored
    wr_parm(8'h21);
    @(negedge clk); chk(parm_rdata == 8'h83, "R9 parm frozen", parm_rdata, 8'h83);

    // power clear while running refused, enable clear accepted
    wr_ctrl(8'h00);
    @(negedge clk); chk(ctrl_rdata[1:0] == 2'b01, "R8 pwr kept", ctrl_rdata[1:0], 1);
    wait_fall("R7 run clears");
    chk(ctrl_rdata[0] == 1'b1, "R8 pwr after stop", ctrl_rdata[0], 1);
    wr_ctrl(8'h00);
    @(negedge clk); chk(ctrl_rdata == 8'h10, "R10 powered off", ctrl_rdata, 8'h10);

    // timed power-up
    power_timed("R2 start-up wait");
    wr_ctrl(8'h01);
    wait_fall("R7 run clears");

    // missing lock blocks start
    pll_locked = 1'b0;
    wr_ctrl(8'h03);
    repeat (10) @(negedge clk);
    chk(!mod_run, "R3 needs lock", mod_run, 0);
    pll_locked = 1'b1;
    @(negedge clk); chk(mod_run, "R3 start on lock", mod_run, 1);
    repeat (100) @(posedge clk);

    // combined: continuous zero write across the stop edge
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'h00;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (mod_run && n < 3000);
    end
    chk(ctrl_rdata[0] == 1'b1, "R8 refused at stop edge", ctrl_rdata[0], 1);
    @(negedge clk); chk(ctrl_rdata == 8'h10, "R8 applied after stop", ctrl_rdata, 8'h10);
    ctrl_we = 1'b0;

    // repowered: full wait again
    power_timed("R10 restart wait");
    wr_ctrl(8'h01);
    wait_fall("R7 run clears");

    // corner: degree 0 and nominal clamp
    run_round(8'h50, 60);
    run_round(8'h0F, 60);
    run_round(8'hF0, 80);
    run_round(8'h39, 120);

    for (int r = 0; r < 8; r++) begin
      logic [7:0] p;
      p = 8'($urandom);
      run_round(p, 150 + int'($urandom % 700));
    end

    chk(!mod_tick, "R11 idle at end", mod_tick, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end
endmodule